// File: doc/BRIEF.md
# Fuse Array Dump Sequencer

This block copies the whole content of a one-time-programmable fuse array into a byte buffer, one byte at a time, in ascending address order. After a single start pulse it takes ownership of the array, points the array at bank 0, and switches off the high-voltage programming regulator. Only then does it begin reading. For every address it issues a read request to the fuse control port. The request carries the address, a zeroed data field and a cleared completion flag. The block then samples the flag at a fixed poll spacing until the array reports completion. At that point it takes the byte from the returned data field and writes it into the buffer with a strobe and the matching address.

When the highest address has been stored, the block releases array ownership and signals completion for one cycle. If any single byte fails to complete within the allowed number of polls, the dump stops. The block then releases ownership, raises an error pulse and reports how many bytes were stored before the failure. The poll spacing and the poll limit are given in clock cycles. The usual setting is one poll per microsecond with a limit of one million polls.

Top module: `fuse_dump_ctrl`

## Requirements
- R1: While reset is asserted and right after it, no request, buffer write, done or error pulse is active, `grant_o` is 0, `ldo25_en_o` is 1, `bank_sel_o` equals BANK_IDLE and `byte_cnt_o` is 0.
- R2: A start pulse accepted in idle is followed by three set-up cycles. In the first, `grant_o` is still 0 and `byte_cnt_o` has been cleared. In the second, `grant_o` is 1. In the third, `bank_sel_o` equals BANK_TARGET. The first request follows, with `ldo25_en_o` at 0.
- R3: Requests pulse `fuse_req_o` for one cycle each, for addresses 0 to PHYS_SIZE-1 strictly in ascending order, one outstanding at a time. Each request carries `fuse_wdata_o` = 0 and `fuse_wflag_o` = 0.
- R4: After a request, `fuse_flag_i` is sampled every POLL_GAP cycles, with the first sample POLL_GAP cycles after the request cycle. The value of the flag between samples has no effect.
- R5: The cycle after a sample that finds the flag at 1, `buf_we_o` pulses for one cycle, with `buf_addr_o` set to the requested address and `buf_data_o` set to `fuse_rdata_i` as sampled. `byte_cnt_o` then increases by one.
- R6: The cycle after the last address is written, `done_o` pulses for one cycle with `grant_o` still 1 and `byte_cnt_o` = PHYS_SIZE. In the following cycle `grant_o` is 0.
- R7: If POLL_LIMIT samples in a row find the flag at 0, `busy_err_o` pulses in the next cycle, with `byte_cnt_o` equal to the number of bytes already written and no further request. In the cycle after that, `grant_o` is 0.
- R8: A flag first seen at 1 on the POLL_LIMIT-th sample completes the byte normally, without an error.
- R9: A start pulse during a dump is ignored, and the outputs follow the running dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a dump (honoured in idle only) |
| done_o | output | 1 | One-cycle pulse after the final byte is stored |
| busy_err_o | output | 1 | One-cycle pulse on a per-byte timeout |
| byte_cnt_o | output | CNT_W | Bytes stored in the current or last dump |
| grant_o | output | 1 | Fuse array ownership |
| bank_sel_o | output | BANK_W | Fuse bank selection |
| ldo25_en_o | output | 1 | Programming regulator enable |
| fuse_req_o | output | 1 | Read request strobe (control word write) |
| fuse_addr_o | output | ADDR_W | Address field of the control word |
| fuse_wdata_o | output | DATA_W | Data field written with a request (always 0) |
| fuse_wflag_o | output | 1 | Completion flag written with a request (always 0) |
| fuse_flag_i | input | 1 | Completion flag read back |
| fuse_rdata_i | input | DATA_W | Data field read back |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | ADDR_W | Buffer write address |
| buf_data_o | output | DATA_W | Buffer write data |

## Verification
Two of the block's functions can fall on the same cycle: the poll that finds the flag set and the expiry of the poll limit, which share the POLL_LIMIT-th sample. The bench's responder sets the flag exactly POLL_LIMIT×POLL_GAP cycles after the request, so it appears just in time for the final sample. The bench then expects a buffer write and a normal finish. With one cycle more of latency, it expects an error pulse with a zero byte count. A start pulse placed in the middle of a poll wait is the second overlap. For that case the cycle-by-cycle model expects the dump to continue unchanged.

// File: rtl/fuse_dump_pkg.sv
package fuse_dump_pkg;

   typedef enum logic [3:0] {
      FD_IDLE   = 4'd0,
      FD_GRANT  = 4'd1,
      FD_BANK   = 4'd2,
      FD_PWR    = 4'd3,
      FD_LAUNCH = 4'd4,
      FD_WAIT   = 4'd5,
      FD_CAPT   = 4'd6,
      FD_DONE   = 4'd7,
      FD_ABORT  = 4'd8
   } fd_state_e;

endpackage

// File: rtl/fuse_poll_timer.sv
module fuse_poll_timer #(
   parameter int unsigned POLL_GAP   = 200,
   parameter int unsigned POLL_LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic poll_o,
   output logic last_o
);

   localparam int unsigned LIM_W = $clog2(POLL_LIMIT + 1);

   logic             gap_hit;
   logic [LIM_W-1:0] poll_q;

   // spacing between samples: a direct strobe or a divider
   generate
      if (POLL_GAP == 1) begin : g_every_cycle
         assign gap_hit = run_i;
      end else begin : g_divider
         localparam int unsigned GAP_W = $clog2(POLL_GAP);
         logic [GAP_W-1:0] gap_q;

         assign gap_hit = run_i && (gap_q == GAP_W'(POLL_GAP - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gap_q <= '0;
            end else if (!run_i || gap_hit) begin
               gap_q <= '0;
            end else begin
               gap_q <= gap_q + 1'b1;
            end
         end
      end
   endgenerate

   assign last_o = (poll_q == LIM_W'(POLL_LIMIT - 1));
   assign poll_o = gap_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_q <= '0;
      end else if (!run_i) begin
         poll_q <= '0;
      end else if (gap_hit && !last_o) begin
         poll_q <= poll_q + 1'b1;
      end
   end

endmodule

// File: rtl/fuse_addr_walker.sv
module fuse_addr_walker #(
   parameter int unsigned PHYS_SIZE = 256,
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned CNT_W     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              last_o
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(PHYS_SIZE - 1);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;

   assign last_o = (addr_q == TOP_ADDR);
   assign addr_o = addr_q;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (clear_i) begin
         addr_q <= '0;
      end else if (step_i && !last_o) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/fuse_seq_fsm.sv
module fuse_seq_fsm
   import fuse_dump_pkg::*;
#(
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned BANK_IDLE   = 1,
   parameter int unsigned BANK_TARGET = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              poll_i,
   input  logic              last_poll_i,
   input  logic              flag_i,
   input  logic              last_addr_i,
   output fd_state_e         state_o,
   output logic              grant_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              ldo_en_o
);

   fd_state_e         st_q, st_d;
   logic              grant_q;
   logic [BANK_W-1:0] bank_q;
   logic              ldo_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         FD_IDLE:   if (start_i) st_d = FD_GRANT;
         FD_GRANT:  st_d = FD_BANK;
         FD_BANK:   st_d = FD_PWR;
         FD_PWR:    st_d = FD_LAUNCH;
         FD_LAUNCH: st_d = FD_WAIT;
         FD_WAIT: begin
            if (poll_i) begin
               if (flag_i) begin
                  st_d = FD_CAPT;
               end else if (last_poll_i) begin
                  st_d = FD_ABORT;
               end
            end
         end
         FD_CAPT:   st_d = last_addr_i ? FD_DONE : FD_LAUNCH;
         FD_DONE:   st_d = FD_IDLE;
         FD_ABORT:  st_d = FD_IDLE;
         default:   st_d = FD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= FD_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   // ownership is held from the grant step until the closing pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
      end else if (st_q == FD_GRANT) begin
         grant_q <= 1'b1;
      end else if (st_q == FD_DONE || st_q == FD_ABORT) begin
         grant_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= BANK_W'(BANK_IDLE);
      end else if (st_q == FD_BANK) begin
         bank_q <= BANK_W'(BANK_TARGET);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ldo_q <= 1'b1;
      end else if (st_q == FD_PWR) begin
         ldo_q <= 1'b0;
      end
   end

   assign state_o  = st_q;
   assign grant_o  = grant_q;
   assign bank_o   = bank_q;
   assign ldo_en_o = ldo_q;

endmodule

// File: rtl/fuse_dump_ctrl.sv
module fuse_dump_ctrl
   import fuse_dump_pkg::*;
#(
   parameter  int unsigned ADDR_W      = 10,
   parameter  int unsigned DATA_W      = 8,
   parameter  int unsigned PHYS_SIZE   = 256,
   parameter  int unsigned POLL_GAP    = 200,
   parameter  int unsigned POLL_LIMIT  = 1000000,
   parameter  int unsigned BANK_W      = 2,
   parameter  int unsigned BANK_IDLE   = 1,
   parameter  int unsigned BANK_TARGET = 0,
   localparam int unsigned CNT_W       = $clog2(PHYS_SIZE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              done_o,
   output logic              busy_err_o,
   output logic [CNT_W-1:0]  byte_cnt_o,
   output logic              grant_o,
   output logic [BANK_W-1:0] bank_sel_o,
   output logic              ldo25_en_o,
   output logic              fuse_req_o,
   output logic [ADDR_W-1:0] fuse_addr_o,
   output logic [DATA_W-1:0] fuse_wdata_o,
   output logic              fuse_wflag_o,
   input  logic              fuse_flag_i,
   input  logic [DATA_W-1:0] fuse_rdata_i,
   output logic              buf_we_o,
   output logic [ADDR_W-1:0] buf_addr_o,
   output logic [DATA_W-1:0] buf_data_o
);

   // elaboration-time parameter checks
   generate
      if (PHYS_SIZE < 1 || PHYS_SIZE > (1 << ADDR_W)) begin : g_bad_size
         $error("fuse_dump_ctrl: PHYS_SIZE must lie in 1..2**ADDR_W");
      end
      if (POLL_GAP < 1 || POLL_LIMIT < 1) begin : g_bad_poll
         $error("fuse_dump_ctrl: POLL_GAP and POLL_LIMIT must be at least 1");
      end
      if (BANK_IDLE >= (1 << BANK_W) || BANK_TARGET >= (1 << BANK_W)) begin : g_bad_bank
         $error("fuse_dump_ctrl: bank codes must fit in BANK_W bits");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("fuse_dump_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   fd_state_e         state;
   logic              poll;
   logic              last_poll;
   logic              last_addr;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] data_q;

   fuse_seq_fsm #(
      .BANK_W      (BANK_W),
      .BANK_IDLE   (BANK_IDLE),
      .BANK_TARGET (BANK_TARGET)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .poll_i      (poll),
      .last_poll_i (last_poll),
      .flag_i      (fuse_flag_i),
      .last_addr_i (last_addr),
      .state_o     (state),
      .grant_o     (grant_o),
      .bank_o      (bank_sel_o),
      .ldo_en_o    (ldo25_en_o)
   );

   fuse_poll_timer #(
      .POLL_GAP   (POLL_GAP),
      .POLL_LIMIT (POLL_LIMIT)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state == FD_WAIT),
      .poll_o (poll),
      .last_o (last_poll)
   );

   fuse_addr_walker #(
      .PHYS_SIZE (PHYS_SIZE),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W)
   ) i_walker (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (state == FD_IDLE && start_i),
      .step_i  (state == FD_CAPT),
      .addr_o  (cur_addr),
      .cnt_o   (byte_cnt_o),
      .last_o  (last_addr)
   );

   // byte is taken on the sample that sees completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (state == FD_WAIT && poll && fuse_flag_i) begin
         data_q <= fuse_rdata_i;
      end
   end

   assign fuse_req_o   = (state == FD_LAUNCH);
   assign fuse_addr_o  = cur_addr;
   assign fuse_wdata_o = '0;
   assign fuse_wflag_o = 1'b0;

   assign buf_we_o     = (state == FD_CAPT);
   assign buf_addr_o   = cur_addr;
   assign buf_data_o   = data_q;

   assign done_o       = (state == FD_DONE);
   assign busy_err_o   = (state == FD_ABORT);

endmodule

// File: rtl/fuse_dump_chk.sv
module fuse_dump_chk #(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned CNT_W       = 9,
   parameter int unsigned BANK_TARGET = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_o,
   input logic              busy_err_o,
   input logic [CNT_W-1:0]  byte_cnt_o,
   input logic              grant_o,
   input logic [BANK_W-1:0] bank_sel_o,
   input logic              ldo25_en_o,
   input logic              fuse_req_o,
   input logic [ADDR_W-1:0] fuse_addr_o,
   input logic              fuse_flag_i,
   input logic              buf_we_o
);

   AST_REQ_PREPARED: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_req_o |-> (grant_o && !ldo25_en_o && bank_sel_o == BANK_W'(BANK_TARGET))); // R2

   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fuse_req_o, buf_we_o, done_o, busy_err_o})); // R3

   AST_WE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> $past(fuse_flag_i)); // R5

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |=> (byte_cnt_o == CNT_W'($past(byte_cnt_o) + 1'b1))); // R5

   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !grant_o)); // R6

   AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err_o |=> (!busy_err_o && !grant_o)); // R7

   AST_ERR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err_o |-> (32'(byte_cnt_o) == 32'(fuse_addr_o))); // R7

endmodule

bind fuse_dump_ctrl fuse_dump_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .BANK_W      (BANK_W),
   .CNT_W       (CNT_W),
   .BANK_TARGET (BANK_TARGET)
) i_chk (.*);

// File: tb/test_fuse_dump_ctrl.sv
`timescale 1ns/1ps
module test_fuse_dump_ctrl;

   localparam int ADDR_W = 10;
   localparam int DATA_W = 8;
   localparam int PHYS   = 12;
   localparam int GAP    = 3;
   localparam int LIMIT  = 5;
   localparam int BANK_W = 2;
   localparam int CNT_W  = $clog2(PHYS + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              done_o, busy_err_o, grant_o, ldo25_en_o;
   logic [CNT_W-1:0]  byte_cnt_o;
   logic [BANK_W-1:0] bank_sel_o;
   logic              fuse_req_o, fuse_wflag_o;
   logic [ADDR_W-1:0] fuse_addr_o, buf_addr_o;
   logic [DATA_W-1:0] fuse_wdata_o, buf_data_o;
   logic              fuse_flag_i = 1'b0;
   logic [DATA_W-1:0] fuse_rdata_i = '0;
   logic              buf_we_o;

   int nchk = 0;
   int nbad = 0;
   int resp_lat = 1;
   int resp_stuck = -1;
   int salt = 0;
   int resp_cnt = 0;
   int resp_adr = 0;
   bit e_ldo = 1'b1;
   int e_bank = 1;

   always #2.5 clk = ~clk;

   fuse_dump_ctrl #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .PHYS_SIZE  (PHYS),
      .POLL_GAP   (GAP),
      .POLL_LIMIT (LIMIT),
      .BANK_W     (BANK_W)
   ) i_fuse_dump_ctrl (.*);

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 29 + salt * 7 + 5) & 255);
   endfunction

   // fuse array responder: flag cleared by a request, set after resp_lat cycles
   always @(negedge clk) begin
      if (fuse_req_o) begin
         fuse_flag_i  = 1'b0;
         fuse_rdata_i = ~pat(int'(fuse_addr_o));
         resp_cnt     = resp_lat;
         resp_adr     = int'(fuse_addr_o);
      end else if (resp_cnt > 0) begin
         resp_cnt = resp_cnt - 1;
         if (resp_cnt == 0 && resp_adr != resp_stuck) begin
            fuse_flag_i  = 1'b1;
            fuse_rdata_i = pat(resp_adr);
         end
      end
   end

   // one cycle of the reference model: wait for the mid-cycle point, drive, compare
   task automatic cyc(input string tag, input bit req, input bit we, input bit dn,
                      input bit er, input bit gr, input int cnt, input int adr,
                      input int dat, input bit drv_start);
      logic [63:0] act, exp;
      @(negedge clk);
      start_i = drv_start;
      act = {fuse_req_o, buf_we_o, done_o, busy_err_o, grant_o, ldo25_en_o,
             2'(bank_sel_o), 8'(byte_cnt_o),
             fuse_req_o ? 10'(fuse_addr_o) : 10'h0,
             buf_we_o ? 10'(buf_addr_o) : 10'h0,
             buf_we_o ? 8'(buf_data_o) : 8'h0,
             8'(fuse_wdata_o), fuse_wflag_o};
      exp = {req, we, dn, er, gr, e_ldo, 2'(e_bank), 8'(cnt),
             req ? 10'(adr) : 10'h0,
             we ? 10'(adr) : 10'h0,
             we ? 8'(dat) : 8'h0,
             8'h0, 1'b0};
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
      end
   endtask

   task automatic run_dump(input int lat, input int stuck_at, input bit poke, input string ctag);
      int m;
      resp_lat   = lat;
      resp_stuck = stuck_at;
      salt++;
      m = (lat + GAP - 1) / GAP;
      @(negedge clk);
      start_i = 1'b1;
      cyc("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R2", 0, 0, 0, 0, 1, 0, 0, 0, 0);
      e_bank = 0;
      cyc("R2", 0, 0, 0, 0, 1, 0, 0, 0, 0);
      e_ldo = 1'b0;
      for (int a = 0; a < PHYS; a++) begin
         cyc("R3", 1, 0, 0, 0, 1, a, a, 0, 0);
         if (a == stuck_at || m > LIMIT) begin
            for (int k = 0; k < LIMIT * GAP; k++)
               cyc("R4", 0, 0, 0, 0, 1, a, 0, 0, 0);
            cyc("R7", 0, 0, 0, 1, 1, a, 0, 0, 0);
            cyc("R7", 0, 0, 0, 0, 0, a, 0, 0, 0);
            return;
         end
         for (int k = 0; k < m * GAP; k++)
            cyc((poke && a == 1) ? "R9" : "R4", 0, 0, 0, 0, 1, a, 0, 0,
                poke && a == 1 && k == 0);
         cyc(ctag, 0, 1, 0, 0, 1, a, a, int'(pat(a)), 0);
      end
      cyc("R6", 0, 0, 1, 0, 1, PHYS, 0, 0, 0);
      cyc("R6", 0, 0, 0, 0, 0, PHYS, 0, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      // R1: state during and after reset
      cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R5: fast responder, one poll per byte
      run_dump(1, -1, 1'b0, "R5");
      // R9: slower responder, start poked in a poll wait
      run_dump(7, -1, 1'b1, "R5");
      // R8: flag arrives exactly for the final permitted poll
      run_dump(LIMIT * GAP, -1, 1'b0, "R8");
      // R7: one cycle too slow, first byte times out
      run_dump(LIMIT * GAP + 1, -1, 1'b0, "R5");
      // R7: stuck flag at address 5 reports five stored bytes
      run_dump(2, 5, 1'b0, "R5");
      // R3: a clean dump after an aborted one
      run_dump(GAP, -1, 1'b0, "R5");
      repeat (3) cyc("R1", 0, 0, 0, 0, 0, PHYS, 0, 0, 0);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule